// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the host-side master for the two-wire serial management bus of an Ethernet PHY. The host presents a single command: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs one complete management frame on its own. It divides the system clock down to produce MDC, and it drives or samples MDIO through a tri-state triple: output value, output enable and input. Every frame starts with a 32-bit all-ones synchronization run. For a read, the block releases the line through the turnaround and data fields, collects the 16 bits the PHY returns, and presents them with a one-cycle completion pulse. For a write, it keeps driving the line and sends a fixed turnaround pattern followed by the data.

The command port uses a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the frame has finished. The block does not store a command offered while `cmd_ready` is low. That command is dropped, and a host that wants it sent must keep `cmd_valid` high until `cmd_ready` returns. The completion side is plain status: `done` pulses once and `rd_data` holds the last read result, with no back-pressure on either. Every field goes out most significant bit first. MDIO changes only on the falling edge of MDC, and read data is captured on the rising edge.

Top module: `mdio_frame_master`

## Requirements
- R1: Whenever no frame is in progress, MDC is low, `mdio_oe` is 0 (line released to the pull-up), `busy` is 0 and `cmd_ready` is 1.
- R2: A command is accepted only on a clock edge with `cmd_valid` and `cmd_ready` both high. `busy` is 1 and `cmd_ready` is 0 from the next cycle until the frame ends. Commands offered while busy start no frame and change nothing on the line.
- R3: Each frame is exactly 64 MDC cycles, one bit per cycle. Its first 32 bits are logic one, driven with `mdio_oe` = 1.
- R4: Bits 32 to 33 are the start pattern 0, 1. Bits 34 to 35 are the opcode: 1, 0 when `cmd_write` = 0 (read) and 0, 1 when `cmd_write` = 1 (write).
- R5: Bits 36 to 40 carry `cmd_phy` and bits 41 to 45 carry `cmd_reg`, each most significant bit first and driven by the master.
- R6: In a write frame the master keeps `mdio_oe` = 1 for all 64 bits. It sends turnaround bits 46 to 47 as 1, 0, then `cmd_wdata` in bits 48 to 63, most significant bit first.
- R7: In a read frame `mdio_oe` is 0 from bit 46 through bit 63. The line value at the 16 rising MDC edges of bits 48 to 63 is collected most significant bit first into `rd_data`.
- R8: MDC has a period of 2*DIV_HALF system clocks with DIV_HALF clocks high. `mdio_o` and `mdio_oe` do not change while MDC is high.
- R9: `done` is a one-cycle pulse on the edge where the 64th MDC cycle falls and `busy` drops. For a read, `rd_data` holds the new value from that edge until the next read completes. A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (no frame running) |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address within the PHY |
| cmd_wdata | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rd_data | output | 16 | Result of the last read frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
The assertions check four things on every cycle: that MDC is low and the line released while idle, that a frame starts only from an offered command, that the MDIO driver holds steady while MDC is high, and that the completion pulse is a single cycle that ends the busy period. Only the scenarios can show that the bit content of a frame is right. That covers the preamble, start, opcode and address ordering, the turnaround pattern for writes against the release for reads, and the reassembly of data returned by a modelled PHY. The scenarios also measure the MDC period and duty, and they show that a command offered mid-frame leaves no trace.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int DATA_LEN   = 16;
  localparam int ADDR_W     = 5;
  localparam int BIT_IDX_W  = $clog2(FRAME_LEN);
  // vector bit index below which a read frame is released
  localparam int RELEASE_VEC = FRAME_LEN - TA_FIRST;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  localparam logic [1:0] SOF_PAT   = 2'b01;
  localparam logic [1:0] WR_TA_PAT = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == LAST);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
(
  input  logic                  is_write,
  input  logic [ADDR_W-1:0]     phy,
  input  logic [ADDR_W-1:0]     regad,
  input  logic [DATA_LEN-1:0]   wdata,
  output logic [FRAME_LEN-1:0]  frame,
  output logic [FRAME_LEN-1:0]  oe_mask
);
  mdio_opc_e opc;

  assign opc   = is_write ? OPC_WRITE : OPC_READ;
  assign frame = {{PRE_LEN{1'b1}}, SOF_PAT, opc, phy, regad,
                  is_write ? WR_TA_PAT : 2'b00,
                  is_write ? wdata : {DATA_LEN{1'b0}}};

  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_oe
    if (i >= RELEASE_VEC) begin : g_drv
      assign oe_mask[i] = 1'b1;
    end else begin : g_sel
      assign oe_mask[i] = is_write;
    end
  end
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_write,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic [FRAME_LEN-1:0] oe_mask,
  input  logic                 rise_stb,
  input  logic                 fall_stb,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_LEN-1:0]  rd_data,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT  = BIT_IDX_W'(FRAME_LEN - 1);
  localparam logic [BIT_IDX_W-1:0] DATA_BIT0 = BIT_IDX_W'(DATA_FIRST);

  logic [FRAME_LEN-1:0] out_sh;
  logic [FRAME_LEN-1:0] oe_sh;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic [DATA_LEN-1:0]  in_sh;
  logic                 is_rd;

  assign mdio_o  = out_sh[FRAME_LEN-1];
  assign mdio_oe = busy & oe_sh[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh  <= '0;
      oe_sh   <= '0;
      bit_idx <= '0;
      in_sh   <= '0;
      is_rd   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          out_sh  <= frame;
          oe_sh   <= oe_mask;
          bit_idx <= '0;
          is_rd   <= !start_write;
          busy    <= 1'b1;
        end
      end else begin
        if (rise_stb && is_rd && (bit_idx >= DATA_BIT0)) begin
          in_sh <= {in_sh[DATA_LEN-2:0], mdio_i};
        end
        if (fall_stb) begin
          if (bit_idx == LAST_BIT) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (is_rd) rd_data <= in_sh;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            out_sh  <= {out_sh[FRAME_LEN-2:0], 1'b1};
            oe_sh   <= {oe_sh[FRAME_LEN-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [FRAME_LEN-1:0] frame;
  logic [FRAME_LEN-1:0] oe_mask;
  logic                 rise_stb;
  logic                 fall_stb;
  logic                 accept;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_build u_build (
    .is_write (cmd_write),
    .phy      (cmd_phy),
    .regad    (cmd_reg),
    .wdata    (cmd_wdata),
    .frame    (frame),
    .oe_mask  (oe_mask)
  );

  mdio_shift_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (cmd_write),
    .frame       (frame),
    .oe_mask     (oe_mask),
    .rise_stb    (rise_stb),
    .fall_stb    (fall_stb),
    .mdio_i      (mdio_i),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
  );
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  p_idle_mdc_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  p_start_from_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  p_drive_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (.*);

// File: tb/mdio_frame_master_test.sv
`timescale 1ns/1ps
module mdio_frame_master_test;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  logic        phy_en = 1'b0;
  logic        phy_val = 1'b1;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_data = '0;
  int          pcount = 0;
  logic [63:0] cap_line = '0;
  logic [63:0] cap_oe = '0;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] last_rd = '0;
  logic [144:0] expq[$];

  always #5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_frame_master #(.DIV_HALF(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // line capture and PHY model
  always @(posedge mdc) begin
    cap_line = {cap_line[62:0], mdio_i};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    pcount++;
    if (pcount == 36) phy_rd = (cap_line[1:0] == 2'b10);
  end

  always @(negedge mdc) begin
    if (phy_rd && pcount == 47) begin
      phy_en  <= 1'b1;
      phy_val <= 1'b0;
    end else if (phy_rd && pcount >= 48 && pcount <= 63) begin
      phy_val <= phy_data[63 - pcount];
    end else if (pcount >= 64) begin
      phy_en <= 1'b0;
    end
  end

  // monitor: pops expectations when a frame completes
  initial begin
    logic [144:0] e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected frame", 64'(pcount), 64'd0);
        end else begin
          e = expq.pop_front();
          check(pcount == 64, "R3 bit count", 64'(pcount), 64'd64);
          check(cap_line == e[144:81], "R3 R4 R5 R6 R7 line bits",
                cap_line, e[144:81]);
          check(cap_oe == e[80:17], "R6 R7 driver enable", cap_oe, e[80:17]);
          check(rd_data == e[16:1], "R7 R9 rd_data", 64'(rd_data), 64'(e[16:1]));
        end
        pcount = 0;
        phy_rd = 1'b0;
        @(negedge clk);
        check(!done && !busy && cmd_ready && !mdc, "R9 single done pulse",
              {60'd0, done, busy, cmd_ready, mdc}, 64'b0010);
      end
    end
  end

  task automatic send(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                      input logic [15:0] wd, input logic [15:0] pd);
    logic [15:0] dat;
    logic [63:0] line, oe;
    while (!cmd_ready) @(negedge clk);
    phy_data = pd;
    dat  = wr ? wd : pd;
    line = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra, 2'b10, dat};
    oe   = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'h0};
    if (!wr) last_rd = pd;
    expq.push_back({line, oe, last_rd, wr});
    cmd_write = wr; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !cmd_ready, "R2 busy after accept",
          {62'd0, busy, cmd_ready}, 64'b10);
  endtask

  task automatic wait_idle();
    while (busy || expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    time t0, t1, t2;
    repeat (3) @(negedge clk);
    check(!mdc && !mdio_oe && !busy && cmd_ready && !done, "R1 reset state",
          {59'd0, mdc, mdio_oe, busy, cmd_ready, done}, 64'b00010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(1'b1, 5'h05, 5'h11, 16'hA5C3, 16'h0000);
    // R8 clock period and duty
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check((t1 - t0) == DIV * 10, "R8 MDC high time", 64'(t1 - t0), 64'(DIV * 10));
    check((t2 - t0) == 2 * DIV * 10, "R8 MDC period", 64'(t2 - t0), 64'(2 * DIV * 10));
    wait_idle();
    check(!mdc && !mdio_oe && mdio_i, "R1 idle released",
          {61'd0, mdc, mdio_oe, mdio_i}, 64'b001);

    send(1'b0, 5'h1F, 5'h00, 16'hFFFF, 16'h8001);
    wait_idle();
    send(1'b0, 5'h00, 5'h1F, 16'h1234, 16'h7E5A);
    wait_idle();

    // R2: commands offered mid-frame are ignored
    send(1'b1, 5'h15, 5'h0A, 16'h0000, 16'h0000);
    repeat (10) @(negedge clk);
    cmd_write = 1'b0; cmd_phy = 5'h0E; cmd_reg = 5'h03; cmd_wdata = 16'hDEAD;
    cmd_valid = 1'b1;
    repeat (5) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);
    check(!busy && !mdc && pcount == 0, "R2 no frame from ignored command",
          64'(pcount), 64'd0);

    send(1'b1, 5'h0A, 5'h15, 16'hFFFF, 16'h0000);
    wait_idle();
    check(rd_data == 16'h7E5A, "R9 rd_data kept after write",
          64'(rd_data), 64'h7E5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule